// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is one DMA channel that copies 32-bit words between a host address space and a local address space. Software programs a few configuration inputs and then controls the channel through a small command/status register. With chaining on, the engine walks a linked list of 16-byte descriptors. For each element it loads the host address, the local address and the byte count, moves the data, and then follows the next pointer until it reaches an element flagged as the final one. With chaining off, it moves one block described by its own address and count inputs.

Both address spaces share one memory request port. A transfer on that port completes in the cycle where `mem_req` and `mem_ready` are both high. Read data returns in that same cycle on `mem_rdata`, and `mem_host` selects the host space (1) or the local space (0). The engine moves each word in two memory operations: it reads the word from the source and then writes it to the destination. Each element can raise an interrupt of its own. The end of the chain can also raise the channel interrupt. An optional mode writes zero back into each finished descriptor's count word.

Top module: `dmac_engine`

## Requirements
- R1: With chaining on, a start fetches four words from `desc_ptr` with bits 3:0 cleared. The words are read in this order: host address (+0), local address (+4), byte count (+8), next pointer (+12). They come from host space when `desc_ptr[0]`=1 and from local space otherwise.
- R2: The engine uses only bits 22:0 of a byte count. It moves count>>2 words and ignores the two low bits. An element whose word count is zero moves no data.
- R3: Bit 3 of an element's next-pointer word picks the direction. 1 reads the local space and writes the host space. 0 reads the host space and writes the local space. Each word is written to the destination with the value just read from the source, and the host address advances by 4 per word.
- R4: Bit 1 of the next-pointer word marks an element as the final one. If bit 1 is clear, the next descriptor is fetched from the pointer with bits 3:0 cleared, in the space that the pointer's bit 0 selects.
- R5: An element whose next-pointer bit 2 is set raises `irq` when that element finishes, whatever `cfg_done_ie` is set to.
- R6: When `cfg_done_ie`=1, the end of the chain raises `irq`. When `cfg_done_ie`=0, it does not. Once raised, `irq` stays high until a command write with bit 3 set.
- R7: Command write bits are 0 enable, 1 start, 2 abort and 3 clear-interrupt. The status output shows enable on bit 0 and done on bit 4. A start is accepted only if bit 0 of the same write is 1 and the channel is idle. An accepted start clears done, and done sets when the final element finishes.
- R8: Writing enable=0 during a transfer pauses the channel with no memory requests. Writing enable=1 again resumes the transfer, and the remaining data still arrives correctly.
- R9: An abort while busy returns the channel to idle at once and sets done. Enable takes bit 0 of the abort write, and no memory write follows the abort.
- R10: With `cfg_chain`=0, a start moves `blk_count`>>2 words between `blk_host_addr` and `blk_local_addr`, in the direction that `blk_to_host` gives. It then ends the chain.
- R11: With `cfg_clr_count`=1 and chaining on, after each element's data the engine writes zero to that descriptor's count word (+8) in the descriptor's own space.
- R12: With `cfg_hold_local`=1, every word of an element uses the same local address.
- R13: While `mem_ready` is low, a pending request keeps its address, direction and write data until it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_we | input | 1 | Command write strobe |
| cs_wdata | input | 4 | Command bits: enable, start, abort, clear-interrupt |
| cs_status | output | 5 | Status: bit 0 enable, bit 4 done |
| irq | output | 1 | Channel interrupt |
| busy | output | 1 | Transfer in progress |
| cfg_chain | input | 1 | 1 = follow descriptor list |
| cfg_clr_count | input | 1 | 1 = zero each finished descriptor count |
| cfg_done_ie | input | 1 | 1 = chain end raises interrupt |
| cfg_hold_local | input | 1 | 1 = local address does not advance |
| blk_host_addr | input | 32 | Host address for unchained mode |
| blk_local_addr | input | 32 | Local address for unchained mode |
| blk_count | input | 23 | Byte count for unchained mode |
| blk_to_host | input | 1 | Unchained direction, 1 = local to host |
| desc_ptr | input | 32 | First descriptor pointer, bit 0 = list in host space |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_host | output | 1 | 1 = host space, 0 = local space |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |

## Verification
A wrong field loaded from a descriptor shows up on the first destination write of that element, one memory operation after the source read: the address, space or data will not match. A wrong next-pointer or final flag appears as an unexpected descriptor fetch or write, or as a missing done, within the next few cycles. A reference model in the bench builds the expected stream of memory writes from the descriptors it has placed in memory. It compares every write in the cycle it occurs, so a stale count or a bad address step shows up at the first word it affects. A bad pause or abort shows up as a request seen while no request is allowed.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_READ  = 3'd2,
        ST_WRITE = 3'd3,
        ST_ZERO  = 3'd4,
        ST_STEP  = 3'd5
    } seq_st_e;

    // command write bit positions
    localparam int CMD_ENABLE = 0;
    localparam int CMD_START  = 1;
    localparam int CMD_ABORT  = 2;
    localparam int CMD_CLRIRQ = 3;
    localparam int CMD_BITS   = 4;

    // status bit positions
    localparam int STS_ENABLE = 0;
    localparam int STS_DONE   = 4;
    localparam int STS_BITS   = 5;

    // next-pointer word flags
    localparam int NP_IN_HOST  = 0;
    localparam int NP_LAST     = 1;
    localparam int NP_LINK_IRQ = 2;
    localparam int NP_TO_HOST  = 3;
    localparam int DESC_ALIGN  = 4;

endpackage

// File: rtl/dmac_csr.sv
module dmac_csr
    import dmac_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_we,
    input  logic [CMD_BITS-1:0] cs_wdata,
    input  logic                busy,
    input  logic                elem_irq,
    input  logic                chain_end,
    input  logic                cfg_done_ie,
    output logic                run,
    output logic                go,
    output logic                halt,
    output logic [STS_BITS-1:0] cs_status,
    output logic                irq
);

    typedef struct packed {
        logic en;
        logic done;
        logic irq;
    } csr_t;

    csr_t q, n;

    always_comb begin
        n    = q;
        go   = cs_we && cs_wdata[CMD_ENABLE] && cs_wdata[CMD_START] && !busy;
        halt = cs_we && cs_wdata[CMD_ABORT] && busy;
        if (cs_we) n.en = cs_wdata[CMD_ENABLE];
        if (go) n.done = 1'b0;
        if (halt || chain_end) n.done = 1'b1;
        if (cs_we && cs_wdata[CMD_CLRIRQ]) n.irq = 1'b0;
        if (elem_irq || (chain_end && cfg_done_ie)) n.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        cs_status             = '0;
        cs_status[STS_ENABLE] = q.en;
        cs_status[STS_DONE]   = q.done;
    end
    assign run = q.en;
    assign irq = q.irq;

    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.irq && !(cs_we && cs_wdata[CMD_CLRIRQ])) |=> q.irq);

    assert_start_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (busy && !q.done));

    assert_abort_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!busy && q.done));

    assert_busy_not_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !q.done);

endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          halt,
    input  logic          run,
    input  logic          cfg_chain,
    input  logic          cfg_clr_count,
    input  logic          cfg_hold_local,
    input  logic [W-1:0]  blk_host_addr,
    input  logic [W-1:0]  blk_local_addr,
    input  logic [CW-1:0] blk_count,
    input  logic          blk_to_host,
    input  logic [W-1:0]  desc_ptr,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_host,
    output logic [W-1:0]  mem_addr,
    output logic [W-1:0]  mem_wdata,
    input  logic          mem_ready,
    input  logic [W-1:0]  mem_rdata,
    output logic          busy,
    output logic          elem_irq,
    output logic          chain_end
);

    localparam int BSH = $clog2(W / 8);
    localparam int WCW = CW - BSH;
    localparam logic [W-1:0] STRIDE = W'(W / 8);
    localparam logic [W-1:0] CNT_OFS = W'(2 * (W / 8));

    typedef struct packed {
        seq_st_e        st;
        logic [W-1:0]   desc_addr;
        logic           desc_host;
        logic [1:0]     widx;
        logic [W-1:0]   host_addr;
        logic [W-1:0]   local_addr;
        logic [WCW-1:0] left;
        logic           to_host;
        logic           last;
        logic           link;
        logic [W-1:0]   next_ptr;
        logic [W-1:0]   data;
    } seq_t;

    seq_t    q, n;
    logic    xfer;
    seq_st_e after_data;
    logic    unused_bits;

    assign unused_bits = ^{desc_ptr[DESC_ALIGN-1:1], blk_count[BSH-1:0]};

    function automatic logic [W-1:0] align_desc(input logic [W-1:0] p);
        return {p[W-1:DESC_ALIGN], {DESC_ALIGN{1'b0}}};
    endfunction

    always_comb begin
        n          = q;
        elem_irq   = 1'b0;
        chain_end  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_host   = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        xfer       = 1'b0;
        after_data = (cfg_chain && cfg_clr_count) ? ST_ZERO : ST_STEP;
        unique case (q.st)
            ST_IDLE: begin
                if (go && cfg_chain) begin
                    n.st        = ST_FETCH;
                    n.desc_addr = align_desc(desc_ptr);
                    n.desc_host = desc_ptr[NP_IN_HOST];
                    n.widx      = '0;
                end else if (go) begin
                    n.host_addr  = blk_host_addr;
                    n.local_addr = blk_local_addr;
                    n.left       = blk_count[CW-1:BSH];
                    n.to_host    = blk_to_host;
                    n.last       = 1'b1;
                    n.link       = 1'b0;
                    n.st         = (blk_count[CW-1:BSH] == '0) ? ST_STEP : ST_READ;
                end
            end
            ST_FETCH: begin
                mem_req  = run;
                mem_host = q.desc_host;
                mem_addr = q.desc_addr + W'({q.widx, 2'b00});
                xfer     = run && mem_ready;
                if (xfer) begin
                    unique case (q.widx)
                        2'd0: n.host_addr  = mem_rdata;
                        2'd1: n.local_addr = mem_rdata;
                        2'd2: n.left       = mem_rdata[CW-1:BSH];
                        default: begin
                            n.next_ptr = mem_rdata;
                            n.last     = mem_rdata[NP_LAST];
                            n.link     = mem_rdata[NP_LINK_IRQ];
                            n.to_host  = mem_rdata[NP_TO_HOST];
                        end
                    endcase
                    n.widx = q.widx + 2'd1;
                    if (q.widx == 2'd3) n.st = (q.left == '0) ? after_data : ST_READ;
                end
            end
            ST_READ: begin
                mem_req  = run;
                mem_host = !q.to_host;
                mem_addr = q.to_host ? q.local_addr : q.host_addr;
                xfer     = run && mem_ready;
                if (xfer) begin
                    n.data = mem_rdata;
                    n.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                mem_req   = run;
                mem_we    = 1'b1;
                mem_host  = q.to_host;
                mem_addr  = q.to_host ? q.host_addr : q.local_addr;
                mem_wdata = q.data;
                xfer      = run && mem_ready;
                if (xfer) begin
                    n.host_addr  = q.host_addr + STRIDE;
                    n.local_addr = cfg_hold_local ? q.local_addr : q.local_addr + STRIDE;
                    n.left       = q.left - 1'b1;
                    n.st         = (q.left == WCW'(1)) ? after_data : ST_READ;
                end
            end
            ST_ZERO: begin
                mem_req  = run;
                mem_we   = 1'b1;
                mem_host = q.desc_host;
                mem_addr = q.desc_addr + CNT_OFS;
                xfer     = run && mem_ready;
                if (xfer) n.st = ST_STEP;
            end
            ST_STEP: begin
                elem_irq = q.link;
                if (q.last) begin
                    chain_end = 1'b1;
                    n.st      = ST_IDLE;
                end else begin
                    n.desc_addr = align_desc(q.next_ptr);
                    n.desc_host = q.next_ptr[NP_IN_HOST];
                    n.widx      = '0;
                    n.st        = ST_FETCH;
                end
            end
            default: n.st = ST_IDLE;
        endcase
        if (halt && q.st != ST_IDLE) begin
            n.st      = ST_IDLE;
            elem_irq  = 1'b0;
            chain_end = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign busy = (q.st != ST_IDLE);

    assert_stall_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready && !halt) |=>
        (!mem_req || ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata) && $stable(mem_host))));

    assert_pause_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !run && !halt) |=> ($stable(q.left) && $stable(q.host_addr) && $stable(q.local_addr)));

    assert_hold_local_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hold_local && q.st == ST_WRITE && mem_req && mem_ready) |=> $stable(q.local_addr));

endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = 23
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_we,
    input  logic [CMD_BITS-1:0] cs_wdata,
    output logic [STS_BITS-1:0] cs_status,
    output logic                irq,
    output logic                busy,
    input  logic                cfg_chain,
    input  logic                cfg_clr_count,
    input  logic                cfg_done_ie,
    input  logic                cfg_hold_local,
    input  logic [W-1:0]        blk_host_addr,
    input  logic [W-1:0]        blk_local_addr,
    input  logic [CW-1:0]       blk_count,
    input  logic                blk_to_host,
    input  logic [W-1:0]        desc_ptr,
    output logic                mem_req,
    output logic                mem_we,
    output logic                mem_host,
    output logic [W-1:0]        mem_addr,
    output logic [W-1:0]        mem_wdata,
    input  logic                mem_ready,
    input  logic [W-1:0]        mem_rdata
);

    logic run, go, halt, elem_irq, chain_end;

    dmac_csr u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_we      (cs_we),
        .cs_wdata   (cs_wdata),
        .busy       (busy),
        .elem_irq   (elem_irq),
        .chain_end  (chain_end),
        .cfg_done_ie(cfg_done_ie),
        .run        (run),
        .go         (go),
        .halt       (halt),
        .cs_status  (cs_status),
        .irq        (irq)
    );

    dmac_seq #(.W(W), .CW(CW)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .go            (go),
        .halt          (halt),
        .run           (run),
        .cfg_chain     (cfg_chain),
        .cfg_clr_count (cfg_clr_count),
        .cfg_hold_local(cfg_hold_local),
        .blk_host_addr (blk_host_addr),
        .blk_local_addr(blk_local_addr),
        .blk_count     (blk_count),
        .blk_to_host   (blk_to_host),
        .desc_ptr      (desc_ptr),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_host      (mem_host),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_ready     (mem_ready),
        .mem_rdata     (mem_rdata),
        .busy          (busy),
        .elem_irq      (elem_irq),
        .chain_end     (chain_end)
    );

endmodule

// File: tb/dmac_engine_bench.sv
`timescale 1ns/1ps
module dmac_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_we = 1'b0;
    logic [3:0]  cs_wdata = '0;
    logic [4:0]  cs_status;
    logic        irq, busy;
    logic        cfg_chain = 1'b0, cfg_clr_count = 1'b0, cfg_done_ie = 1'b0, cfg_hold_local = 1'b0;
    logic [31:0] blk_host_addr = '0, blk_local_addr = '0, desc_ptr = '0;
    logic [22:0] blk_count = '0;
    logic        blk_to_host = 1'b0;
    logic        mem_req, mem_we, mem_host;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b1;

    logic [31:0] host_mem [0:255];
    logic [31:0] loc_mem  [0:255];
    logic [64:0] exp_q [$];

    int    checks = 0, errors = 0;
    int    stall_seen = 0, pause_viol = 0;
    bit    stall_mode = 1'b0, paused = 1'b0, finished = 1'b0;
    string cur_tag = "R13";

    always #5 clk = ~clk;

    assign mem_rdata = mem_host ? host_mem[mem_addr[9:2]] : loc_mem[mem_addr[9:2]];

    dmac_engine u_dmac_engine (.*);

    task automatic check(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model and per-cycle write comparison
    always @(negedge clk) begin
        if (rst_n && mem_req && !mem_ready) stall_seen++;
        if (rst_n && paused && mem_req) pause_viol++;
        if (rst_n && mem_req && mem_ready && mem_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_tag, " unexpected write"}, {mem_host, mem_addr, mem_wdata}, '0);
            end else begin
                logic [64:0] e;
                e = exp_q.pop_front();
                check(e == {mem_host, mem_addr, mem_wdata}, cur_tag, {mem_host, mem_addr, mem_wdata}, e);
            end
            if (mem_host) host_mem[mem_addr[9:2]] = mem_wdata;
            else          loc_mem[mem_addr[9:2]]  = mem_wdata;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #1;
            mem_ready = stall_mode ? ~mem_ready : 1'b1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic init_mem();
        for (int i = 0; i < 256; i++) begin
            host_mem[i] = 32'hA000_0000 + i;
            loc_mem[i]  = 32'hB000_0000 + i;
        end
    endtask

    task automatic put_desc(input bit in_host, input logic [31:0] a, input logic [31:0] h,
                            input logic [31:0] l, input logic [31:0] c, input logic [31:0] np);
        if (in_host) begin
            host_mem[a[9:2]] = h; host_mem[a[9:2]+1] = l; host_mem[a[9:2]+2] = c; host_mem[a[9:2]+3] = np;
        end else begin
            loc_mem[a[9:2]] = h; loc_mem[a[9:2]+1] = l; loc_mem[a[9:2]+2] = c; loc_mem[a[9:2]+3] = np;
        end
    endtask

    // behavioural expectation of the writes one element produces
    task automatic model_elem(input logic [31:0] h, input logic [31:0] l, input logic [31:0] cnt,
                              input bit to_host, input bit hold);
        int words;
        words = int'((cnt & 32'h007F_FFFF) >> 2);
        for (int i = 0; i < words; i++) begin
            logic [31:0] ha, la;
            ha = h + 4 * i;
            la = hold ? l : l + 4 * i;
            if (to_host) exp_q.push_back({1'b1, ha, loc_mem[la[9:2]]});
            else         exp_q.push_back({1'b0, la, host_mem[ha[9:2]]});
        end
    endtask

    task automatic cs_write(input logic [3:0] d);
        @(negedge clk);
        cs_we = 1'b1; cs_wdata = d;
        @(negedge clk);
        cs_we = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int t = 0;
        while (busy && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(t < 3000, {tag, " completion"}, 65'(t), 65'd0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        init_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R7)
        check(cs_status == 5'h00, "R7 reset status", 65'(cs_status), 65'h0);
        check(!irq && !busy && !mem_req, "R7 reset outputs", {irq, busy, mem_req}, 65'h0);

        // R10 unchained block host->local, R6 done interrupt
        cur_tag = "R10";
        cfg_chain = 0; cfg_done_ie = 1;
        blk_host_addr = 32'h100; blk_local_addr = 32'h040; blk_count = 23'd12; blk_to_host = 0;
        model_elem(32'h100, 32'h040, 32'd12, 1'b0, 1'b0);
        cs_write(4'h3);
        wait_idle("R10");
        check(exp_q.size() == 0, "R10 all words moved", 65'(exp_q.size()), 65'd0);
        check(cs_status == 5'h11, "R7 done and enable", 65'(cs_status), 65'h11);
        check(irq == 1'b1, "R6 chain end raises irq", 65'(irq), 65'd1);
        repeat (3) @(negedge clk);
        check(irq == 1'b1, "R6 irq sticky", 65'(irq), 65'd1);
        cs_write(4'h9);
        check(irq == 1'b0, "R6 clear interrupt", 65'(irq), 65'd0);
        check(cs_status == 5'h11, "R7 clear does not start", 65'(cs_status), 65'h11);

        // R1 R2 R3 R4 R13 two-element chain across both spaces, with stalls
        init_mem();
        cur_tag = "R1 R2 R3 R4 R13";
        cfg_chain = 1; cfg_done_ie = 0; stall_mode = 1;
        put_desc(1'b1, 32'h300, 32'h100, 32'h040, 32'd8, 32'h380);
        put_desc(1'b0, 32'h380, 32'h180, 32'h080, 32'hFF80_0007, 32'h0000_000A);
        model_elem(32'h100, 32'h040, 32'd8, 1'b0, 1'b0);
        model_elem(32'h180, 32'h080, 32'hFF80_0007, 1'b1, 1'b0);
        desc_ptr = 32'h30D;
        cs_write(4'h3);
        wait_idle("R4");
        check(exp_q.size() == 0, "R4 chain followed to last", 65'(exp_q.size()), 65'd0);
        check(host_mem[8'h60] == 32'hB000_0020, "R3 local to host data", 65'(host_mem[8'h60]), 65'hB000_0020);
        check(irq == 1'b0, "R6 no irq when done_ie off", 65'(irq), 65'd0);
        check(cs_status == 5'h11, "R7 done after chain", 65'(cs_status), 65'h11);
        check(stall_seen > 0, "R13 stalls exercised", 65'(stall_seen), 65'd1);
        stall_mode = 0;

        // R5 link interrupt, R2 zero-word element
        init_mem();
        cur_tag = "R5 R2";
        put_desc(1'b1, 32'h340, 32'h100, 32'h000, 32'd3, 32'h351);
        put_desc(1'b1, 32'h350, 32'h140, 32'h0C0, 32'd4, 32'h0000_0006);
        model_elem(32'h140, 32'h0C0, 32'd4, 1'b0, 1'b0);
        desc_ptr = 32'h341;
        cs_write(4'h3);
        wait_idle("R5");
        check(exp_q.size() == 0, "R2 zero element moves nothing", 65'(exp_q.size()), 65'd0);
        check(irq == 1'b1, "R5 link interrupt", 65'(irq), 65'd1);
        cs_write(4'h8);

        // R11 clear-count mode, list in local space
        init_mem();
        cur_tag = "R11";
        cfg_clr_count = 1; cfg_done_ie = 1;
        put_desc(1'b0, 32'h3C0, 32'h1C0, 32'h0D0, 32'd4, 32'h3D0);
        put_desc(1'b0, 32'h3D0, 32'h1D0, 32'h0E0, 32'd8, 32'h0000_000A);
        model_elem(32'h1C0, 32'h0D0, 32'd4, 1'b0, 1'b0);
        exp_q.push_back({1'b0, 32'h3C8, 32'h0});
        model_elem(32'h1D0, 32'h0E0, 32'd8, 1'b1, 1'b0);
        exp_q.push_back({1'b0, 32'h3D8, 32'h0});
        desc_ptr = 32'h3C0;
        cs_write(4'h3);
        wait_idle("R11");
        check(exp_q.size() == 0, "R11 counts zeroed", 65'(exp_q.size()), 65'd0);
        check(loc_mem[8'hF2] == 32'h0, "R11 count word", 65'(loc_mem[8'hF2]), 65'h0);
        cfg_clr_count = 0;
        cs_write(4'h8);

        // R12 hold local address
        init_mem();
        cur_tag = "R12";
        cfg_chain = 0; cfg_hold_local = 1;
        blk_host_addr = 32'h1E0; blk_local_addr = 32'h0F0; blk_count = 23'd12; blk_to_host = 1;
        model_elem(32'h1E0, 32'h0F0, 32'd12, 1'b1, 1'b1);
        cs_write(4'h3);
        wait_idle("R12");
        check(exp_q.size() == 0, "R12 fixed local address", 65'(exp_q.size()), 65'd0);
        check(host_mem[8'h7A] == 32'hB000_003C, "R12 repeated word", 65'(host_mem[8'h7A]), 65'hB000_003C);
        cfg_hold_local = 0;
        cs_write(4'h8);

        // R8 pause and resume
        init_mem();
        cur_tag = "R8";
        blk_host_addr = 32'h100; blk_local_addr = 32'h000; blk_count = 23'd32; blk_to_host = 0;
        model_elem(32'h100, 32'h000, 32'd32, 1'b0, 1'b0);
        cs_write(4'h3);
        repeat (4) @(negedge clk);
        cs_write(4'h0);
        paused = 1;
        repeat (20) @(negedge clk);
        paused = 0;
        check(pause_viol == 0, "R8 no requests while paused", 65'(pause_viol), 65'd0);
        check(busy == 1'b1, "R8 still busy when paused", 65'(busy), 65'd1);
        cs_write(4'h1);
        wait_idle("R8");
        check(exp_q.size() == 0, "R8 resumed to completion", 65'(exp_q.size()), 65'd0);
        check(cs_status == 5'h11, "R8 done after resume", 65'(cs_status), 65'h11);
        cs_write(4'h8);

        // R9 abort
        init_mem();
        cur_tag = "R9";
        blk_count = 23'd64;
        model_elem(32'h100, 32'h000, 32'd64, 1'b0, 1'b0);
        cs_write(4'h3);
        repeat (6) @(negedge clk);
        cs_write(4'h5);
        exp_q.delete();
        check(busy == 1'b0, "R9 idle after abort", 65'(busy), 65'd0);
        check(cs_status == 5'h11, "R9 done set enable kept", 65'(cs_status), 65'h11);
        repeat (10) @(negedge clk);
        check(irq == 1'b0, "R9 abort raises no irq", 65'(irq), 65'd0);

        // R7 start without enable bit is ignored
        cur_tag = "R7";
        cs_write(4'h2);
        repeat (5) @(negedge clk);
        check(busy == 1'b0 && !mem_req, "R7 start needs enable", {busy, mem_req}, 65'd0);
        check(cs_status == 5'h10, "R7 status after ignored start", 65'(cs_status), 65'h10);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule